// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block controls a single bank of up to 32 general-purpose pins from a plain 32-bit register bus. Software sets the pin direction and output enable through two read/write registers. It reads the live pin levels, after they have been synchronized, from a read-only register. The output latch is never written as a whole word. It is updated through two write-only half-bank ports. Each port carries a 16-bit write mask above 16 data bits, so one pin, or any subset of a half bank, changes in a single bus write with no read-modify-write.

A pin drives its pad only when it is configured as an output and its output enable is set. The bank width is a parameter. Pins above the implemented count read as zero, ignore writes and are never driven. The bus is single-cycle: a write takes effect at the clock edge where `bus_valid` and `bus_write` are both high, and read data is returned combinationally while a read is presented.

Top module: `gpio_mw_bank`

## Requirements
- R1: While reset (`rst_n` low) is sampled, the direction, output-enable and output latch registers clear. After reset, `pin_out` and `pin_drive` are all zero and the direction and enable registers read back as zero.
- R2: A write to offset 0x000 updates latch bits 15:0. Write-data bit k+16 is the mask for latch bit k and bit k is its new value. The bit takes the new value only where its mask bit is 0 and keeps its old value where the mask bit is 1. Latch bits 31:16 do not change.
- R3: A write to offset 0x004 updates latch bits 31:16 under the same mask rule, with pin n taking data bit n-16. Latch bits 15:0 do not change.
- R4: A read of offset 0x060 returns one bit per pin, giving the level present on `pin_in` two clock edges earlier (two-stage synchronizer).
- R5: The direction register at offset 0x204 is read/write; a 1 marks a pin as output and a 0 marks it as input.
- R6: The output-enable register at offset 0x208 is read/write.
- R7: `pin_drive[n]` is 1 exactly when direction bit n and enable bit n are both 1. `pin_out` always shows the output latch.
- R8: With `NUM_PINS` below 32, bits at or above `NUM_PINS` read as 0 at every register and are never driven. Writes to those bits have no effect.
- R9: Reads of the write-only offsets 0x000 and 0x004 and of any unmapped offset return 0. Writes to unmapped offsets change no register.
- R10: `bus_rdata` is 0 whenever no read is presented (`bus_valid` low or `bus_write` high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Asynchronous pad levels |
| pin_out | output | 32 | Output latch value to the pads |
| pin_drive | output | 32 | Per-pin pad drive enable |

## Verification
The hardest case to reach is a masked write that changes only some bits of a half bank while the other half and the masked bits must hold. The bench first loads a known pattern, then issues writes whose masks cover all bits, none or a single bit, and checks every latch bit afterwards. The synchronizer delay is checked by changing `pin_in` and reading on the very next cycle, then again one cycle later. Unimplemented pins are reached through a second instance built with 22 pins, which is written with all-ones patterns at every offset.

// File: rtl/gpio_mw_pkg.sv
// Shared constants and types for the masked-write GPIO bank.
// Assumes a 32-bit data bus; the offsets are byte addresses.
package gpio_mw_pkg;
    localparam int BUS_W   = 32;
    localparam int HALF_W  = 16;
    localparam int OFF_MW_LO = 32'h000;
    localparam int OFF_MW_HI = 32'h004;
    localparam int OFF_PINS  = 32'h060;
    localparam int OFF_DIR   = 32'h204;
    localparam int OFF_OE    = 32'h208;

    // Write strobes produced by the decoder
    typedef struct packed {
        logic lo;
        logic hi;
        logic dir;
        logic oe;
    } wr_sel_t;

    // Read source produced by the decoder
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PINS = 2'd1,
        RSEL_DIR  = 2'd2,
        RSEL_OE   = 2'd3
    } rsel_t;

    // Mask with one bit set for each implemented pin
    function automatic logic [BUS_W-1:0] impl_mask(input int n);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < BUS_W; i++) m[i] = (i < n);
        return m;
    endfunction
endpackage

// File: rtl/gpio_mw_decode.sv
// Address decoder: turns one bus access into write strobes and a read select.
// Assumes full-width address compare; any other offset decodes to nothing.
module gpio_mw_decode
    import gpio_mw_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output wr_sel_t           wsel,
    output rsel_t             rsel
);
    logic hit_lo, hit_hi, hit_pins, hit_dir, hit_oe;

    // Compare the address against each mapped offset
    always_comb begin
        hit_lo   = (addr == ADDR_W'(OFF_MW_LO));
        hit_hi   = (addr == ADDR_W'(OFF_MW_HI));
        hit_pins = (addr == ADDR_W'(OFF_PINS));
        hit_dir  = (addr == ADDR_W'(OFF_DIR));
        hit_oe   = (addr == ADDR_W'(OFF_OE));
    end

    // Write strobes fire only for writable offsets
    always_comb begin
        wsel.lo  = valid && write && hit_lo;
        wsel.hi  = valid && write && hit_hi;
        wsel.dir = valid && write && hit_dir;
        wsel.oe  = valid && write && hit_oe;
    end

    // Read select; write-only and unmapped offsets give RSEL_NONE
    always_comb begin
        rsel = RSEL_NONE;
        if (valid && !write) begin
            if (hit_pins)     rsel = RSEL_PINS;
            else if (hit_dir) rsel = RSEL_DIR;
            else if (hit_oe)  rsel = RSEL_OE;
        end
    end
endmodule

// File: rtl/gpio_mw_sync.sv
// Multi-stage flop synchronizer for asynchronous pin levels.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_mw_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the asynchronous input
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= din;
            end
        end else begin : g_next
            // Later stages shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_mw_cfg_reg.sv
// Plain read/write configuration register with an implemented-bit mask.
// Assumes IMPL marks the writable bits; the others stay at zero.
module gpio_mw_cfg_reg #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load on write, clear on reset, keep unimplemented bits at zero
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata & IMPL;
    end
endmodule

// File: rtl/gpio_mw_out_latch.sv
// Output data latch updated through two masked half-word ports.
// Assumes mask in the upper half-word (1 = keep) and data in the lower.
module gpio_mw_out_latch
    import gpio_mw_pkg::*;
#(
    parameter logic [BUS_W-1:0] IMPL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] q
);
    localparam int NHALF = BUS_W / HALF_W;

    logic [HALF_W-1:0] keep;
    logic [HALF_W-1:0] val;

    // Split the write word into its mask and data fields
    always_comb begin
        keep = wdata[BUS_W-1:HALF_W];
        val  = wdata[HALF_W-1:0];
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic we_h;
        logic [HALF_W-1:0] impl_h;
        assign we_h   = (h == 0) ? we_lo : we_hi;
        assign impl_h = IMPL[h*HALF_W +: HALF_W];

        // Merge the new data into this half where the mask allows
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[h*HALF_W +: HALF_W] <= '0;
            else if (we_h)
                q[h*HALF_W +: HALF_W] <= ((q[h*HALF_W +: HALF_W] & keep)
                                         | (val & ~keep)) & impl_h;
        end
    end
endmodule

// File: rtl/gpio_mw_bank.sv
// One GPIO bank with direction, output enable, masked-write output latch
// and synchronized pin readback. Assumes a single-cycle register bus:
// writes commit on the clock edge, reads return combinationally.
module gpio_mw_bank
    import gpio_mw_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pin_in,
    output logic [31:0]       pin_out,
    output logic [31:0]       pin_drive
);
    localparam logic [BUS_W-1:0] IMPL = impl_mask(NUM_PINS);

    wr_sel_t          wsel;
    rsel_t            rsel;
    logic [BUS_W-1:0] pins_sync;
    logic [BUS_W-1:0] dir_q;
    logic [BUS_W-1:0] oe_q;
    logic [BUS_W-1:0] latch_q;

    gpio_mw_decode #(.ADDR_W(ADDR_W)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .wsel  (wsel),
        .rsel  (rsel)
    );

    gpio_mw_sync #(.W(BUS_W), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in & IMPL),
        .dout  (pins_sync)
    );

    gpio_mw_cfg_reg #(.W(BUS_W), .IMPL(IMPL)) u_dir (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wsel.dir),
        .wdata (bus_wdata),
        .q     (dir_q)
    );

    gpio_mw_cfg_reg #(.W(BUS_W), .IMPL(IMPL)) u_oe (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wsel.oe),
        .wdata (bus_wdata),
        .q     (oe_q)
    );

    gpio_mw_out_latch #(.IMPL(IMPL)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .we_lo (wsel.lo),
        .we_hi (wsel.hi),
        .wdata (bus_wdata),
        .q     (latch_q)
    );

    // Select the read source; anything else returns zero
    always_comb begin
        unique case (rsel)
            RSEL_PINS: bus_rdata = pins_sync;
            RSEL_DIR:  bus_rdata = dir_q;
            RSEL_OE:   bus_rdata = oe_q;
            default:   bus_rdata = '0;
        endcase
    end

    // Pad outputs: latch value and drive only for enabled outputs
    always_comb begin
        pin_out   = latch_q;
        pin_drive = dir_q & oe_q;
    end
endmodule

// File: rtl/gpio_mw_bank_chk.sv
// Assertion checker bound to gpio_mw_bank; observes ports only.
module gpio_mw_bank_chk #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       pin_out,
    input logic [31:0]       pin_drive
);
    localparam logic [31:0] IMPL = gpio_mw_pkg::impl_mask(NUM_PINS);

    logic wr_lo, wr_hi, wr_oe_zero;
    assign wr_lo      = bus_valid && bus_write && (bus_addr == ADDR_W'(32'h000));
    assign wr_hi      = bus_valid && bus_write && (bus_addr == ADDR_W'(32'h004));
    assign wr_oe_zero = bus_valid && bus_write && (bus_addr == ADDR_W'(32'h208))
                        && (bus_wdata == 32'h0);

    // R1: reset leaves pads undriven and the latch clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (pin_out == 32'h0 && pin_drive == 32'h0));

    // R2: low masked write merges data where the mask bit is 0
    a_r2_low_merge: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> pin_out[15:0] == ((($past(pin_out[15:0]) & $past(bus_wdata[31:16]))
                   | ($past(bus_wdata[15:0]) & ~$past(bus_wdata[31:16]))) & IMPL[15:0]));

    // R2: low masked write leaves the upper half alone
    a_r2_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> $stable(pin_out[31:16]));

    // R3: high masked write leaves the lower half alone
    a_r3_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> $stable(pin_out[15:0]));

    // R7: clearing the enable register stops all driving
    a_r7_oe_zero_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        wr_oe_zero |=> pin_drive == 32'h0);

    // R8: unimplemented pins never drive or hold data
    a_r8_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~IMPL) == 32'h0) && ((pin_drive & ~IMPL) == 32'h0));

    // R9: write-only offsets read back as zero
    a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == ADDR_W'(32'h000) || bus_addr == ADDR_W'(32'h004)))
        |-> bus_rdata == 32'h0);

    // R10: idle bus returns zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |-> bus_rdata == 32'h0);
endmodule

bind gpio_mw_bank gpio_mw_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_drive (pin_drive)
);

// File: tb/gpio_mw_bank_bench.sv
// Directed bench: a full 32-pin bank and a 22-pin bank on one bus.
module gpio_mw_bank_bench;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          v_a = 1'b0, v_b = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   pins = '0;
    logic [31:0]   rd_a, rd_b, out_a, out_b, drv_a, drv_b;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;  // 50 MHz

    gpio_mw_bank #(.NUM_PINS(32), .ADDR_W(AW)) u_gpio_mw_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(v_a), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_a),
        .pin_in(pins), .pin_out(out_a), .pin_drive(drv_a)
    );

    gpio_mw_bank #(.NUM_PINS(22), .ADDR_W(AW)) u_gpio_mw_bank_n22 (
        .clk(clk), .rst_n(rst_n), .bus_valid(v_b), .bus_write(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_b),
        .pin_in(pins), .pin_out(out_b), .pin_drive(drv_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // Write one word; commits at the next rising edge
    task automatic bus_wr(input bit to_b, input int a, input logic [31:0] d);
        @(negedge clk);
        v_a = !to_b; v_b = to_b; wr = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        v_a = 1'b0; v_b = 1'b0; wr = 1'b0;
    endtask

    // Read one word combinationally, mid-cycle
    task automatic bus_rd(input bit from_b, input int a, output logic [31:0] d);
        @(negedge clk);
        v_a = !from_b; v_b = from_b; wr = 1'b0; addr = AW'(a);
        #2;
        d = from_b ? rd_b : rd_a;
        v_a = 1'b0; v_b = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 pin_out after reset", out_a, 32'h0);
        check("R1 pin_drive after reset", drv_a, 32'h0);
        bus_rd(0, 'h204, d); check("R1 dir after reset", d, 32'h0);
        bus_rd(0, 'h208, d); check("R1 oe after reset", d, 32'h0);
    endtask

    task automatic t_masked_low();
        bus_wr(0, 'h000, 32'h0000_A5A5);
        check("R2 low full write", out_a, 32'h0000_A5A5);
        bus_wr(0, 'h000, 32'hFFFE_0000);
        check("R2 single pin clear", out_a, 32'h0000_A5A4);
        bus_wr(0, 'h000, 32'hFFFF_5A5A);
        check("R2 all masked no change", out_a, 32'h0000_A5A4);
        bus_wr(0, 'h000, 32'h7FFF_8000);
        check("R2 bit15 set kept bit14", out_a, 32'h0000_A5A4);
    endtask

    task automatic t_masked_high();
        bus_wr(0, 'h004, 32'h00FF_1234);
        check("R3 high partial mask", out_a, 32'h1200_A5A4);
        bus_wr(0, 'h004, 32'hFFFE_0001);
        check("R3 pin16 from data bit0", out_a, 32'h1201_A5A4);
    endtask

    task automatic t_dir_oe();
        logic [31:0] d;
        bus_wr(0, 'h204, 32'hF0F0_F0F0);
        bus_rd(0, 'h204, d); check("R5 dir readback", d, 32'hF0F0_F0F0);
        check("R7 no drive without oe", drv_a, 32'h0);
        bus_wr(0, 'h208, 32'hFF00_FF00);
        bus_rd(0, 'h208, d); check("R6 oe readback", d, 32'hFF00_FF00);
        check("R7 drive is dir and oe", drv_a, 32'hF000_F000);
        check("R7 pin_out is latch", out_a, 32'h1201_A5A4);
    endtask

    task automatic t_sync();
        logic [31:0] d;
        @(negedge clk); pins = 32'hDEAD_BEEF;
        bus_rd(0, 'h060, d); check("R4 one edge still old", d, 32'h0);
        bus_rd(0, 'h060, d); check("R4 two edges new", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        bus_rd(0, 'h000, d); check("R9 read low mw zero", d, 32'h0);
        bus_rd(0, 'h004, d); check("R9 read high mw zero", d, 32'h0);
        bus_rd(0, 'h100, d); check("R9 read unmapped zero", d, 32'h0);
        bus_wr(0, 'h300, 32'hFFFF_FFFF);
        bus_wr(0, 'h064, 32'h0000_0000);
        bus_rd(0, 'h204, d); check("R9 dir unchanged", d, 32'hF0F0_F0F0);
        bus_rd(0, 'h208, d); check("R9 oe unchanged", d, 32'hFF00_FF00);
        check("R9 latch unchanged", out_a, 32'h1201_A5A4);
        @(negedge clk); v_a = 1'b0; wr = 1'b0; addr = AW'('h204); #2;
        check("R10 idle rdata zero", rd_a, 32'h0);
        @(negedge clk); v_a = 1'b1; wr = 1'b1; wdata = 32'h0; addr = AW'('h100); #2;
        check("R10 write cycle rdata zero", rd_a, 32'h0);
        @(negedge clk); v_a = 1'b0; wr = 1'b0;
    endtask

    task automatic t_narrow();
        logic [31:0] d;
        bus_wr(1, 'h204, 32'hFFFF_FFFF);
        bus_rd(1, 'h204, d); check("R8 dir upper bits zero", d, 32'h003F_FFFF);
        bus_wr(1, 'h208, 32'hFFFF_FFFF);
        check("R8 drive only implemented", drv_b, 32'h003F_FFFF);
        bus_wr(1, 'h004, 32'h0000_FFFF);
        check("R8 high write trimmed", out_b, 32'h003F_0000);
        @(negedge clk); pins = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        bus_rd(1, 'h060, d); check("R8 pin read trimmed", d, 32'h003F_FFFF);
        check("R8 wide bank unaffected", out_a, 32'h1201_A5A4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked_low();
        t_masked_high();
        t_dir_oe();
        t_sync();
        t_unmapped();
        t_narrow();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule